// File: doc/BRIEF.md
# I/O Bus Command Decoder

This block sits beside a processor that reports the type of each bus cycle only as a 3-bit status code. The block watches that code and tracks the four bus states T1 to T4 of each cycle. From them it produces the strobes that an I/O subsystem needs: an I/O read command and two write commands, one early and one normal. It also produces an address latch pulse, a data direction level and a data buffer enable. The commands are active low. The latch pulse and the buffer enable are active high. The direction output is high for transmit and low for receive.

The block runs on a clock at twice the bus-state rate, so every bus state has two halves. This half-state resolution lets the data enable end halfway through T4 on reads, and it lets the normal write command trail the early one by half a state. Status code `111` means passive. Code `001` is an I/O read and `010` is an I/O write. Every other code starts a cycle that is not an I/O cycle: it gets the latch pulse and state tracking, but no command and no buffer enable.

Top module: `iobus_cmd_ctrl`

## Requirements
- R1: While reset is low, and in the clock after reset is released, all three commands are high, `ale` and `den` are low and `dt_r` is high. A reset in the middle of a cycle drops the cycle.
- R2: A cycle starts at a rising edge that samples a non-passive code (not `111`), provided that no cycle is running and `111` has been sampled since reset or since the last start. A code held active across many clocks starts only one cycle.
- R3: A cycle occupies eight clocks after its start edge, numbered 0 to 7. Clocks 0 and 1 are T1, clocks 2 and 3 are T2, clocks 4 and 5 are T3, and clocks 6 and 7 are T4. `ale` is high in clock 0 only.
- R4: In a read cycle (code `001`), `ior_n` is low in clocks 2 to 5 and high otherwise.
- R5: In a write cycle (code `010`), `aiow_n` is low in clocks 2 to 5.
- R6: In a write cycle, `iow_n` is low in clocks 3 to 5, half a bus state after `aiow_n` falls.
- R7: `den` is high in clocks 2 to 6 of a read cycle and in clocks 2 to 7 of a write cycle.
- R8: `dt_r` is low in clocks 0 to 7 of a read cycle and high at all other times.
- R9: A cycle started by any other non-passive code gives `ale` in clock 0 and nothing else: all commands stay high, `den` stays low and `dt_r` stays high.
- R10: Changes of the status code during a running cycle do not alter that cycle. The block is idle again in the clock after clock 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at two ticks per bus state |
| rst_n | input | 1 | Active-low synchronous reset |
| stat | input | 3 | Processor bus status code |
| ale | output | 1 | Address latch pulse, active high |
| dt_r | output | 1 | Data direction: 1 transmit, 0 receive |
| den | output | 1 | Data buffer enable, active high |
| ior_n | output | 1 | I/O read command, active low |
| iow_n | output | 1 | I/O write command, active low |
| aiow_n | output | 1 | Early I/O write command, active low |

## Verification
The outputs decode registered state, so a code sampled at start edge k shows its clock-j value in the period that follows edge k+j. `ale` therefore appears one period after the status leaves passive, and the read command appears three periods after it. The bench drives the status on falling edges. Its behavioural model advances on the same rising edge as the design, and every output is compared at the next falling edge. The code that started the cycle and any later status changes are both judged against that model at the same sample point.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_IORD  = 2'd1,
    CK_IOWR  = 2'd2,
    CK_OTHER = 2'd3
  } cyc_kind_e;

  // true when tick s lies within [lo, hi]
  function automatic logic in_span(input int s, input int lo, input int hi);
    return (s >= lo) && (s <= hi);
  endfunction

  // tick index of a half inside a bus state (T1 is state 0)
  function automatic int tick_of(input int t_state, input int half, input int halves);
    return t_state * halves + half;
  endfunction

endpackage

// File: rtl/bsc_status_decode.sv
module bsc_status_decode
  import bsc_pkg::*;
#(
  parameter int STAT_W = 3,
  parameter logic [STAT_W-1:0] CODE_PASSIVE = 3'b111,
  parameter logic [STAT_W-1:0] CODE_IORD    = 3'b001,
  parameter logic [STAT_W-1:0] CODE_IOWR    = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  input  logic              idle,
  output logic              start,
  output cyc_kind_e         kind
);

  logic armed;
  logic is_passive;

  function automatic cyc_kind_e classify(input logic [STAT_W-1:0] c);
    if (c == CODE_IORD)      return CK_IORD;
    else if (c == CODE_IOWR) return CK_IOWR;
    else if (c == CODE_PASSIVE) return CK_NONE;
    else                     return CK_OTHER;
  endfunction

  assign is_passive = (stat == CODE_PASSIVE);
  assign kind       = classify(stat);
  assign start      = idle && armed && !is_passive;

  // a passive sample re-arms; a start consumes the arm
  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b0;
    else if (start)      armed <= 1'b0;
    else if (is_passive) armed <= 1'b1;
  end

  // R2: one start per passive-to-active transition
  p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start);

endmodule

// File: rtl/bsc_tstate_seq.sv
module bsc_tstate_seq
  import bsc_pkg::*;
#(
  parameter int SLOTS = 8,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  cyc_kind_e         kind_in,
  output logic              busy,
  output logic [SLOT_W-1:0] slot,
  output cyc_kind_e         kind_q
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      slot   <= '0;
      kind_q <= CK_NONE;
    end else if (start) begin
      busy   <= 1'b1;
      slot   <= '0;
      kind_q <= kind_in;
    end else if (busy) begin
      if (slot == LAST) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + SLOT_W'(1);
      end
    end
  end

  // R10: a running cycle advances one tick per clock and ends after the last
  p_tick_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != LAST) |=> (busy && slot == $past(slot) + SLOT_W'(1)));
  p_cycle_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot == LAST) |=> !busy);

endmodule

// File: rtl/bsc_strobe_gen.sv
module bsc_strobe_gen
  import bsc_pkg::*;
#(
  parameter int HALVES   = 2,
  parameter int T_STATES = 4,
  localparam int SLOTS  = HALVES * T_STATES,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              busy,
  input  logic [SLOT_W-1:0] slot,
  input  cyc_kind_e         kind,
  output logic              ale,
  output logic              dt_r,
  output logic              den,
  output logic              ior_n,
  output logic              iow_n,
  output logic              aiow_n
);

  localparam int ALE_LO    = tick_of(0, 0, HALVES);
  localparam int ALE_HI    = tick_of(0, HALVES/2 - 1, HALVES);
  localparam int CMD_LO    = tick_of(1, 0, HALVES);
  localparam int IOW_LO    = tick_of(1, HALVES/2, HALVES);
  localparam int CMD_HI    = tick_of(2, HALVES - 1, HALVES);
  localparam int DEN_RD_HI = tick_of(3, HALVES/2 - 1, HALVES);
  localparam int DEN_WR_HI = SLOTS - 1;

  always_comb begin
    int s;
    s      = int'(slot);
    ale    = 1'b0;
    dt_r   = 1'b1;
    den    = 1'b0;
    ior_n  = 1'b1;
    iow_n  = 1'b1;
    aiow_n = 1'b1;
    if (busy) begin
      ale = in_span(s, ALE_LO, ALE_HI);
      case (kind)
        CK_IORD: begin
          dt_r  = 1'b0;
          ior_n = !in_span(s, CMD_LO, CMD_HI);
          den   = in_span(s, CMD_LO, DEN_RD_HI);
        end
        CK_IOWR: begin
          aiow_n = !in_span(s, CMD_LO, CMD_HI);
          iow_n  = !in_span(s, IOW_LO, CMD_HI);
          den    = in_span(s, CMD_LO, DEN_WR_HI);
        end
        default: ;
      endcase
    end
  end

  // R4/R5: read and write commands never overlap
  always_comb begin
    if (busy) assert (ior_n || (aiow_n && iow_n));
  end

endmodule

// File: rtl/iobus_cmd_ctrl.sv
module iobus_cmd_ctrl
  import bsc_pkg::*;
#(
  parameter int STAT_W   = 3,
  parameter int HALVES   = 2,
  parameter int T_STATES = 4,
  parameter logic [STAT_W-1:0] CODE_PASSIVE = 3'b111,
  parameter logic [STAT_W-1:0] CODE_IORD    = 3'b001,
  parameter logic [STAT_W-1:0] CODE_IOWR    = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  output logic              ale,
  output logic              dt_r,
  output logic              den,
  output logic              ior_n,
  output logic              iow_n,
  output logic              aiow_n
);

  localparam int SLOTS  = HALVES * T_STATES;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic              start_w;
  logic              busy_w;
  logic [SLOT_W-1:0] slot_w;
  cyc_kind_e         kind_now_w;
  cyc_kind_e         kind_q_w;

  bsc_status_decode #(
    .STAT_W(STAT_W), .CODE_PASSIVE(CODE_PASSIVE),
    .CODE_IORD(CODE_IORD), .CODE_IOWR(CODE_IOWR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .stat(stat), .idle(!busy_w),
    .start(start_w), .kind(kind_now_w)
  );

  bsc_tstate_seq #(.SLOTS(SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_w), .kind_in(kind_now_w),
    .busy(busy_w), .slot(slot_w), .kind_q(kind_q_w)
  );

  bsc_strobe_gen #(.HALVES(HALVES), .T_STATES(T_STATES)) u_gen (
    .busy(busy_w), .slot(slot_w), .kind(kind_q_w),
    .ale(ale), .dt_r(dt_r), .den(den),
    .ior_n(ior_n), .iow_n(iow_n), .aiow_n(aiow_n)
  );

  // R3: the latch pulse follows a start edge
  p_ale_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(start_w));
  // R8: a read command always sees the receive direction
  p_read_receives_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ior_n |-> !dt_r);
  // R7: buffer enabled whenever the read command falls
  p_den_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ior_n) |-> den);
  // R6: normal write falls only after the early write is already low
  p_iow_lags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iow_n) |-> $past(!aiow_n));
  // R5: early write is held once asserted
  p_aiow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aiow_n) |=> !aiow_n);

endmodule

// File: tb/iobus_cmd_ctrl_test.sv
module iobus_cmd_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic ale, dt_r, den, ior_n, iow_n, aiow_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural reference: tick -1 means idle, kind 1 read, 2 write, 3 other
  int m_tick = -1;
  bit m_armed = 0;
  int m_kind = 0;
  int ale_pulses = 0;
  logic ale_prev = 1'b0;

  always #2 clk = ~clk;

  iobus_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .stat(stat),
    .ale(ale), .dt_r(dt_r), .den(den),
    .ior_n(ior_n), .iow_n(iow_n), .aiow_n(aiow_n)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tick  <= -1;
      m_armed <= 0;
      m_kind  <= 0;
    end else if (m_tick < 0 && m_armed && stat != 3'b111) begin
      m_tick  <= 0;
      m_armed <= 0;
      m_kind  <= (stat == 3'b001) ? 1 : (stat == 3'b010) ? 2 : 3;
    end else begin
      if (stat == 3'b111) m_armed <= 1;
      if (m_tick >= 0) m_tick <= (m_tick == 7) ? -1 : m_tick + 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit rd, wr;
    rd = (m_tick >= 0) && (m_kind == 1);
    wr = (m_tick >= 0) && (m_kind == 2);
    chk("R3 ale (R2 start, R9, R10)", ale, m_tick == 0);
    chk("R4 ior_n", ior_n, !(rd && m_tick >= 2 && m_tick <= 5));
    chk("R5 aiow_n", aiow_n, !(wr && m_tick >= 2 && m_tick <= 5));
    chk("R6 iow_n", iow_n, !(wr && m_tick >= 3 && m_tick <= 5));
    chk("R7 den", den, (rd && m_tick >= 2 && m_tick <= 6) || (wr && m_tick >= 2));
    chk("R8 dt_r", dt_r, !rd);
  endtask

  // one clock: compare at the falling edge, then drive the next code
  task automatic step(input logic [2:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (ale && !ale_prev) ale_pulses++;
      ale_prev = ale;
      stat = code;
    end
  endtask

  task automatic chk_idle_r1();
    chk("R1 ale", ale, 1'b0);
    chk("R1 den", den, 1'b0);
    chk("R1 dt_r", dt_r, 1'b1);
    chk("R1 ior_n", ior_n, 1'b1);
    chk("R1 iow_n", iow_n, 1'b1);
    chk("R1 aiow_n", aiow_n, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle_r1();                    // R1 during reset
    rst_n = 1'b1;
    step(3'b111, 4);
    chk_idle_r1();                    // R1 after release

    step(3'b001, 5); step(3'b111, 8); // read cycle, R4 R7 R8
    step(3'b010, 5); step(3'b111, 8); // write cycle, R5 R6 R7
    step(3'b100, 3); step(3'b111, 8); // other code, R9
    step(3'b000, 2); step(3'b111, 8); // other code, R9

    // R2: code held active starts exactly one cycle
    ale_pulses = 0;
    step(3'b001, 30);
    checks++;
    if (ale_pulses != 1) begin
      failures++;
      $display("FAIL R2 held code actual=%0d expected=1 pulses", ale_pulses);
    end
    step(3'b111, 3);

    // R10: codes changing during a cycle do not alter it
    step(3'b001, 1); step(3'b111, 2); step(3'b010, 3); step(3'b111, 3);
    step(3'b010, 12); step(3'b111, 4);

    // R1: reset in the middle of a write cycle
    step(3'b010, 3);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle_r1();
    stat = 3'b111;
    @(negedge clk);
    rst_n = 1'b1;
    step(3'b111, 3);

    // mixed codes, including fast toggles
    for (int i = 0; i < 2000; i++) begin
      logic [2:0] c;
      c = ($urandom % 3 == 0) ? 3'b111 : 3'($urandom);
      step(c, 1 + ($urandom % 4));
    end
    step(3'b111, 10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule